// File: doc/BRIEF.md
# Four-Entry Fully Associative Word Cache with Age-Based Replacement

This block is a small read cache between a requester and a slower word memory. It holds four 32-bit words. Any word may sit in any of the four slots, so every lookup compares the requested word address against all stored tags at once. A hit answers in the same cycle as the request. A miss starts a refill on a simple request/valid handshake toward memory. The word that comes back is stored in a chosen slot and handed to the requester in the same cycle it arrives.

Each slot keeps an age: how many other distinct slots have been referenced since this one was last used. A hit or a refill resets the referenced slot's age to zero. Only the slots that were younger than it age by one, so the ages of the occupied slots always form a strict recency order. Empty slots are filled first. Once all four are occupied, the slot with the largest age is replaced.

Top module: `fa_lru_cache`

## Requirements
- R1: After reset every slot is empty: req_ready is 1, resp_valid and mem_req are 0, and the first lookup of any address misses.
- R2: A request whose word is cached is accepted with resp_valid=1, resp_hit=1 and the stored word on resp_data in the same cycle, and mem_req stays 0.
- R3: A request that misses gives resp_valid=0 in its cycle. From the next cycle, mem_req is 1 and mem_addr holds the word address with its two low bits zero. Both stay unchanged, with req_ready=0, until mem_valid is seen.
- R4: In the cycle mem_valid is 1 during a refill, resp_valid=1, resp_hit=0 and resp_data equals mem_data. From then on the word is cached and later hits return that value.
- R5: The tag is the whole word address (bits 31:2). Byte addresses that differ only in bits 1:0 hit the same slot.
- R6: Misses to distinct words occupy empty slots before any occupied slot is replaced, so four distinct misses after reset leave all four words cached.
- R7: A miss with all slots occupied replaces the least recently referenced word, and only that word.
- R8: A hit makes its slot the most recently referenced one, so that slot is replaced last.
- R9: The ages of occupied slots are always pairwise distinct and smaller than the number of occupied slots.
- R10: After reset, the byte-address sequence 24, 20, 4, 12, 20, 44 gives a hit on the second 20. The refill for 44 evicts the word at 24, and 20, 4 and 12 remain cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Cache can accept a lookup this cycle |
| req_addr | input | 32 | Byte address of the lookup |
| resp_valid | output | 1 | Response word valid this cycle |
| resp_hit | output | 1 | Response came from a stored slot |
| resp_data | output | 32 | Response word |
| mem_req | output | 1 | Refill request toward memory |
| mem_addr | output | 32 | Word-aligned refill address |
| mem_valid | input | 1 | Refill word present |
| mem_data | input | 32 | Refill word |

## Verification
Assertions check the recency ordering on every cycle: occupied ages are distinct and below the occupancy count, and at most one slot matches a tag. They also check the refill handshake each cycle: the request and address are held steady, and the requester side is stalled while a refill is pending. Which word a miss actually replaces, and whether data survives across many references, shows only at the ports over long runs. The bench scenarios compare every hit, miss and returned word against an independent timestamp-based replacement model, under random traffic and the directed sequences.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } fill_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int NUM   = 4,
  parameter int TAG_W = 30,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic [NUM-1:0]            valid_i,
  input  logic [NUM-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]          key_i,
  output logic [NUM-1:0]            hit_vec_o,
  output logic                      hit_any_o,
  output logic [IDX_W-1:0]          hit_idx_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  assign hit_any_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_age_lru.sv
module fa_age_lru #(
  parameter int NUM = 4,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic [NUM-1:0]   valid_o,
  output logic [IDX_W-1:0] victim_o
);
  logic [NUM-1:0][IDX_W-1:0] age_q, age_d;
  logic [NUM-1:0]            valid_q, valid_d;
  logic [IDX_W:0]            ref_old;

  // Age the referenced slot held before this reference; an empty slot counts as older than all.
  always_comb begin
    if (valid_q[upd_idx_i]) ref_old = {1'b0, age_q[upd_idx_i]};
    else                    ref_old = (IDX_W+1)'(NUM);
  end

  always_comb begin
    age_d   = age_q;
    valid_d = valid_q;
    if (upd_en_i) begin
      for (int i = 0; i < NUM; i++) begin
        if (valid_q[i] && ({1'b0, age_q[i]} < ref_old)) age_d[i] = age_q[i] + 1'b1;
      end
      age_d[upd_idx_i]   = '0;
      valid_d[upd_idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      age_q   <= '0;
    end else if (upd_en_i) begin
      valid_q <= valid_d;
      age_q   <= age_d;
    end
  end

  // Lowest empty slot first, else the slot with the oldest age.
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (!valid_q[i] && !found) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < NUM; i++) begin
        if (age_q[i] == IDX_W'(NUM-1)) victim_o = IDX_W'(i);
      end
    end
  end

  assign valid_o = valid_q;

  logic           age_clash;
  logic           age_oob;
  logic [IDX_W:0] occ_cnt;
  always_comb begin
    age_clash = 1'b0;
    age_oob   = 1'b0;
    occ_cnt   = '0;
    for (int i = 0; i < NUM; i++) occ_cnt = occ_cnt + (IDX_W+1)'(valid_q[i]);
    for (int i = 0; i < NUM; i++) begin
      if (valid_q[i] && ({1'b0, age_q[i]} >= occ_cnt)) age_oob = 1'b1;
      for (int j = i + 1; j < NUM; j++) begin
        if (valid_q[i] && valid_q[j] && (age_q[i] == age_q[j])) age_clash = 1'b1;
      end
    end
  end

  // R9: occupied ages stay a strict order
  a_r9_ages_distinct: assert property (@(posedge clk) disable iff (!rst_n) !age_clash);
  a_r9_age_in_range:  assert property (@(posedge clk) disable iff (!rst_n) !age_oob);
  // R6: a slot, once filled, is never emptied except by reset
  a_r6_valid_sticky:  assert property (@(posedge clk) disable iff (!rst_n)
                                       1'b1 |=> ((valid_q & $past(valid_q)) == $past(valid_q)));
endmodule

// File: rtl/fa_lru_cache.sv
module fa_lru_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM    = 4,
  localparam int IDX_W = $clog2(NUM),
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data
);
  fill_state_e               state_q, state_d;
  logic [TAG_W-1:0]          miss_tag_q;
  logic [NUM-1:0][TAG_W-1:0] tag_q;
  logic [NUM-1:0][DATA_W-1:0] data_q;

  logic [TAG_W-1:0] key;
  logic [NUM-1:0]   valid, hit_vec;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx, victim, upd_idx;
  logic             hit_fire, miss_fire, fill_fire, upd_en;
  logic             unused_off;

  assign key        = req_addr[ADDR_W-1:OFF_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  fa_tag_match #(.NUM(NUM), .TAG_W(TAG_W)) u_match (
    .valid_i   (valid),
    .tags_i    (tag_q),
    .key_i     (key),
    .hit_vec_o (hit_vec),
    .hit_any_o (hit_any),
    .hit_idx_o (hit_idx)
  );

  fa_age_lru #(.NUM(NUM)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en_i  (upd_en),
    .upd_idx_i (upd_idx),
    .valid_o   (valid),
    .victim_o  (victim)
  );

  assign req_ready = (state_q == ST_LOOKUP);
  assign hit_fire  = req_ready && req_valid && hit_any;
  assign miss_fire = req_ready && req_valid && !hit_any;
  assign fill_fire = (state_q == ST_FILL) && mem_valid;
  assign upd_en    = hit_fire || fill_fire;
  // The victim is read live: ages cannot move while a refill is pending.
  assign upd_idx   = fill_fire ? victim : hit_idx;

  assign resp_valid = hit_fire || fill_fire;
  assign resp_hit   = hit_fire;
  assign resp_data  = fill_fire ? mem_data : data_q[hit_idx];
  assign mem_req    = (state_q == ST_FILL);
  assign mem_addr   = {miss_tag_q, {OFF_W{1'b0}}};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOKUP: if (miss_fire) state_d = ST_FILL;
      ST_FILL:   if (mem_valid) state_d = ST_LOOKUP;
      default:   state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOOKUP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (miss_fire) miss_tag_q <= key;
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[victim]  <= miss_tag_q;
      data_q[victim] <= mem_data;
    end
  end

  // R2: at most one slot can match a lookup
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  // R3: a pending refill holds its request and address until data arrives
  a_r3_req_held:     assert property (@(posedge clk) disable iff (!rst_n)
                                      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
  a_r3_stall:        assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !req_ready);
  // R3: a miss starts a refill on the following cycle
  a_r3_miss_starts:  assert property (@(posedge clk) disable iff (!rst_n) miss_fire |=> mem_req);
  // R4: refill response is never flagged as a hit
  a_r4_fill_resp:    assert property (@(posedge clk) disable iff (!rst_n)
                                      (mem_req && mem_valid) |-> (resp_valid && !resp_hit));
endmodule

// File: tb/tb_fa_lru_cache.sv
`timescale 1ns/1ps
module tb_fa_lru_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        resp_valid;
  logic        resp_hit;
  logic [31:0] resp_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_data;

  always #2.5 clk = ~clk;

  fa_lru_cache dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Reference model: slots with last-use stamps.
  logic [29:0] m_tag   [4];
  bit          m_valid [4];
  int          m_stamp [4];
  int          m_now;

  function automatic logic [31:0] word_val(input logic [29:0] w);
    return ({w, 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int model_find(input logic [29:0] w);
    for (int i = 0; i < 4; i++) if (m_valid[i] && m_tag[i] == w) return i;
    return -1;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 4; i++) begin m_valid[i] = 1'b0; m_stamp[i] = 0; end
    m_now = 1;
  endfunction

  function automatic void model_touch(input logic [29:0] w);
    int k;
    k = model_find(w);
    if (k < 0) begin
      for (int i = 0; i < 4; i++) if (!m_valid[i] && k < 0) k = i;
      if (k < 0) begin
        k = 0;
        for (int i = 1; i < 4; i++) if (m_stamp[i] < m_stamp[k]) k = i;
      end
      m_valid[k] = 1'b1;
      m_tag[k]   = w;
    end
    m_stamp[k] = m_now;
    m_now++;
  endfunction

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input string rq);
    logic [29:0] w;
    bit          exp_hit;
    logic [31:0] exp_d;
    int          d;
    w       = a[31:2];
    exp_hit = (model_find(w) >= 0);
    exp_d   = word_val(w);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    check(rq, "req_ready", 32'(req_ready), 32'd1);
    check(rq, "resp_valid on lookup", 32'(resp_valid), 32'(exp_hit));
    check(rq, "mem_req on lookup", 32'(mem_req), 32'd0);
    if (exp_hit) begin
      check(rq, "resp_hit", 32'(resp_hit), 32'd1);
      check(rq, "hit data", resp_data, exp_d);
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = $urandom;
    if (!exp_hit) begin
      #1;
      check(rq, "mem_req after miss", 32'(mem_req), 32'd1);
      if (mem_req) begin
        d = $urandom_range(0, 3);
        for (int k = 0; k < d; k++) begin
          check(rq, "mem_addr", mem_addr, {w, 2'b00});
          check(rq, "req_ready during refill", 32'(req_ready), 32'd0);
          check(rq, "resp_valid during refill", 32'(resp_valid), 32'd0);
          @(negedge clk);
          #1;
          check(rq, "mem_req held", 32'(mem_req), 32'd1);
        end
        check(rq, "mem_addr", mem_addr, {w, 2'b00});
        mem_valid = 1'b1;
        mem_data  = exp_d;
        #1;
        check(rq, "fill resp_valid", 32'(resp_valid), 32'd1);
        check(rq, "fill resp_hit", 32'(resp_hit), 32'd0);
        check(rq, "fill data", resp_data, exp_d);
        @(negedge clk);
        mem_valid = 1'b0;
        mem_data  = $urandom;
      end
    end
    model_touch(w);
  endtask

  task automatic expect_hit(input logic [31:0] a, input bit h, input string rq);
    check(rq, $sformatf("model residency of %0d", a), 32'(model_find(a[31:2]) >= 0), 32'(h));
    access(a, rq);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    mem_valid = 1'b0;
    mem_data  = '0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "req_ready after reset", 32'(req_ready), 32'd1);
    check("R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    check("R1", "mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    do_reset();

    // R10 / R1 / R6: directed sequence from empty
    expect_hit(32'd24, 1'b0, "R1");
    expect_hit(32'd20, 1'b0, "R6");
    expect_hit(32'd4,  1'b0, "R6");
    expect_hit(32'd12, 1'b0, "R6");
    expect_hit(32'd20, 1'b1, "R10");
    expect_hit(32'd44, 1'b0, "R10");
    expect_hit(32'd20, 1'b1, "R10");
    expect_hit(32'd4,  1'b1, "R10");
    expect_hit(32'd12, 1'b1, "R10");
    expect_hit(32'd44, 1'b1, "R10");
    expect_hit(32'd24, 1'b0, "R10");

    // R5: other byte offsets within a cached word
    expect_hit(32'd27, 1'b1, "R5");
    expect_hit(32'd25, 1'b1, "R5");

    // R8 / R7: refresh the oldest, then a new miss must evict the next oldest
    do_reset();
    expect_hit(32'h100, 1'b0, "R6");
    expect_hit(32'h200, 1'b0, "R6");
    expect_hit(32'h300, 1'b0, "R6");
    expect_hit(32'h400, 1'b0, "R6");
    expect_hit(32'h100, 1'b1, "R8");
    expect_hit(32'h500, 1'b0, "R7");
    expect_hit(32'h100, 1'b1, "R8");
    expect_hit(32'h300, 1'b1, "R7");
    expect_hit(32'h400, 1'b1, "R7");
    expect_hit(32'h500, 1'b1, "R4");
    expect_hit(32'h200, 1'b0, "R7");

    // R2 / R3 / R4 / R7 / R8: random traffic over a small word pool
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = {22'h0, 4'($urandom_range(0, 6)), 4'h0, 2'($urandom)} + 32'h8000;
      access(a, "R7");
    end

    // R1: reset empties the cache again
    do_reset();
    expect_hit(32'h8000, 1'b0, "R1");
    expect_hit(32'h8000, 1'b1, "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule